// File: doc/BRIEF.md
# Priority Blink-Code Status LED

This block drives a single status LED with a repeating frame of eight time slots. Several fault flags arrive in a fixed priority order. At the start of each frame the block picks the most urgent active flag and looks up its code length N in a parameter table. For the whole frame, the LED is lit for the first N slots and dark for the rest. An observer can therefore tell which fault is present by counting the lit slots at the head of each frame.

A slot-tick strobe paces the frames. It is a single-cycle enable, synchronous to the clock, and each tick moves the frame forward by one slot. When no flag was active at the last frame boundary, the LED is idle. In idle it either follows a user-supplied signal or holds a fixed level, depending on a parameter. The default parameters describe a processor-status indicator: a held reset button, init failure, both error flags together, error-status alone, error alone, and configuration not done. A power-status indicator is the same block with a three-entry table (8, 2, 1) and a steady lit idle level.

Top module: `blink_code_led`

## Requirements
- R1: While rstN is low at a clock edge, the block returns to slot 0 in the idle state. It stays idle until the first frame boundary after reset.
- R2: The slot index advances by one only on cycles where slotTick is high. On a tick in slot SLOT_COUNT-1 it wraps to 0, and that tick is the frame boundary.
- R3: While a code of length N is latched, ledOut is 1 during slots 0 to N-1 and 0 during slots N to SLOT_COUNT-1.
- R4: When several flags are active at a boundary, the code of the lowest-numbered flag is chosen. Bit 0 of condFlags has the highest priority.
- R5: The flags are sampled only at a frame boundary. The new code, or idle, takes effect from slot 0 of the next frame, so no frame is ever shown partly.
- R6: With IDLE_FOLLOW=1, ledOut equals userLed in the same cycle while the block is idle.
- R7: With IDLE_FOLLOW=0, ledOut is held at IDLE_LEVEL while the block is idle, and userLed has no effect.
- R8: The default table maps flag bits 0 to 5 to code lengths 8, 5, 4, 3, 2 and 1. Entry i of CODE_LENS sits in bits [4i+3:4i].
- R9: A flag that rises and falls again between two boundaries has no effect on ledOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| slotTick | input | 1 | One-cycle strobe that advances the slot |
| condFlags | input | NUM_COND | Fault flags; bit 0 has the highest priority |
| userLed | input | 1 | Level shown while idle when IDLE_FOLLOW=1 |
| ledOut | output | 1 | LED drive |

## Verification
The assertions assume three things about the inputs:
- slotTick, condFlags and userLed are synchronous to clk.
- Every table entry is no larger than SLOT_COUNT.
- A tick held high for several cycles counts as several separate slot steps.

The stimulus changes every input only on the falling clock edge. It pulses slotTick either on every cycle or on sparse cycles. It raises and drops flags in the middle of frames, and it keeps all table values in the range 1 to 8.

// File: rtl/blink_code_pkg.sv
package blink_code_pkg;

  // width of one code-length entry in the pattern table
  localparam int CodeLenW = 4;

  // strobes from frame control to the code datapath
  typedef struct packed {
    logic frameLoad;   // last slot ticking over: sample the flags now
  } blinkStrobe_t;

endpackage

// File: rtl/blink_frame_ctrl.sv
module blink_frame_ctrl
  import blink_code_pkg::*;
#(
  parameter int SLOT_COUNT = 8,
  parameter int SLOT_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotTick,
  output logic [SLOT_W-1:0] slotIdx,
  output blinkStrobe_t      strobe
);

  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(SLOT_COUNT - 1);

  logic lastSlot;

  assign lastSlot = (slotIdx == LastSlot);

  always_comb begin
    strobe           = '0;
    strobe.frameLoad = slotTick && lastSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotIdx <= '0;
    end else if (slotTick) begin
      slotIdx <= lastSlot ? '0 : slotIdx + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/blink_code_dp.sv
module blink_code_dp
  import blink_code_pkg::*;
#(
  parameter int                           NUM_COND    = 6,
  parameter int                           SLOT_W      = 3,
  parameter logic [NUM_COND*CodeLenW-1:0] CODE_LENS   = 24'h123458,
  parameter bit                           IDLE_FOLLOW = 1'b1,
  parameter bit                           IDLE_LEVEL  = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  blinkStrobe_t        strobe,
  input  logic [SLOT_W-1:0]   slotIdx,
  input  logic [NUM_COND-1:0] condFlags,
  input  logic                userLed,
  output logic [CodeLenW-1:0] activeLen,
  output logic                activeValid,
  output logic                ledOut
);

  logic [CodeLenW-1:0] lenTab [NUM_COND];
  logic [CodeLenW-1:0] selLen;
  logic                selValid;
  logic                slotLit;
  logic                idleDrive;

  // unpack the pattern table, one entry per flag
  for (genvar g = 0; g < NUM_COND; g++) begin : g_tab
    assign lenTab[g] = CODE_LENS[g*CodeLenW +: CodeLenW];
  end

  // fixed-priority pick: scanning from the lowest priority up, a later hit wins
  always_comb begin
    selValid = 1'b0;
    selLen   = '0;
    for (int i = NUM_COND - 1; i >= 0; i--) begin
      if (condFlags[i]) begin
        selValid = 1'b1;
        selLen   = lenTab[i];
      end
    end
  end

  // latched code: changes only at the frame boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeValid <= 1'b0;
      activeLen   <= '0;
    end else if (strobe.frameLoad) begin
      activeValid <= selValid;
      activeLen   <= selValid ? selLen : '0;
    end
  end

  assign slotLit   = CodeLenW'(slotIdx) < activeLen;
  assign idleDrive = IDLE_FOLLOW ? userLed : IDLE_LEVEL;
  assign ledOut    = activeValid ? slotLit : idleDrive;

endmodule

// File: rtl/blink_code_led.sv
module blink_code_led
  import blink_code_pkg::*;
#(
  parameter int                           NUM_COND    = 6,
  parameter int                           SLOT_COUNT  = 8,
  parameter logic [NUM_COND*CodeLenW-1:0] CODE_LENS   = 24'h123458,
  parameter bit                           IDLE_FOLLOW = 1'b1,
  parameter bit                           IDLE_LEVEL  = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slotTick,
  input  logic [NUM_COND-1:0] condFlags,
  input  logic                userLed,
  output logic                ledOut
);

  localparam int SLOT_W = $clog2(SLOT_COUNT);

  logic [SLOT_W-1:0]   slotIdx;
  blinkStrobe_t        strobe;
  logic [CodeLenW-1:0] activeLen;
  logic                activeValid;

  blink_frame_ctrl #(
    .SLOT_COUNT(SLOT_COUNT),
    .SLOT_W    (SLOT_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .slotTick(slotTick),
    .slotIdx (slotIdx),
    .strobe  (strobe)
  );

  blink_code_dp #(
    .NUM_COND   (NUM_COND),
    .SLOT_W     (SLOT_W),
    .CODE_LENS  (CODE_LENS),
    .IDLE_FOLLOW(IDLE_FOLLOW),
    .IDLE_LEVEL (IDLE_LEVEL)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slotIdx    (slotIdx),
    .condFlags  (condFlags),
    .userLed    (userLed),
    .activeLen  (activeLen),
    .activeValid(activeValid),
    .ledOut     (ledOut)
  );

endmodule

// File: rtl/blink_code_led_chk.sv
module blink_code_led_chk
  import blink_code_pkg::*;
#(
  parameter int                           NUM_COND    = 6,
  parameter int                           SLOT_COUNT  = 8,
  parameter int                           SLOT_W      = 3,
  parameter logic [NUM_COND*CodeLenW-1:0] CODE_LENS   = 24'h123458,
  parameter bit                           IDLE_FOLLOW = 1'b1,
  parameter bit                           IDLE_LEVEL  = 1'b0
) (
  input logic                clk,
  input logic                rstN,
  input logic                slotTick,
  input logic [NUM_COND-1:0] condFlags,
  input logic                userLed,
  input logic                ledOut,
  input logic [SLOT_W-1:0]   slotIdx,
  input blinkStrobe_t        strobe,
  input logic [CodeLenW-1:0] activeLen,
  input logic                activeValid
);

  localparam logic [SLOT_W-1:0]   LastSlot = SLOT_W'(SLOT_COUNT - 1);
  localparam logic [CodeLenW-1:0] TopLen   = CODE_LENS[CodeLenW-1:0];

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotTick && slotIdx == LastSlot |=> slotIdx == '0);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotTick && slotIdx != LastSlot |=> slotIdx == SLOT_W'($past(slotIdx) + SLOT_W'(1)));

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(slotIdx));

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameLoad |=> $stable(activeLen) && $stable(activeValid));

  // R4
  top_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameLoad && condFlags[0] |=> activeValid && activeLen == TopLen);

  // R3
  lit_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeValid && (CodeLenW'(slotIdx) < activeLen) |-> ledOut);

  // R3
  dark_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeValid && (CodeLenW'(slotIdx) >= activeLen) |-> !ledOut);

  // R6
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeValid |-> ledOut == (IDLE_FOLLOW ? userLed : IDLE_LEVEL));

endmodule

bind blink_code_led blink_code_led_chk #(
  .NUM_COND   (NUM_COND),
  .SLOT_COUNT (SLOT_COUNT),
  .SLOT_W     (SLOT_W),
  .CODE_LENS  (CODE_LENS),
  .IDLE_FOLLOW(IDLE_FOLLOW),
  .IDLE_LEVEL (IDLE_LEVEL)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .slotTick   (slotTick),
  .condFlags  (condFlags),
  .userLed    (userLed),
  .ledOut     (ledOut),
  .slotIdx    (slotIdx),
  .strobe     (strobe),
  .activeLen  (activeLen),
  .activeValid(activeValid)
);

// File: tb/blink_code_led_tb_top.sv
`timescale 1ns/1ps
module blink_code_led_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slotTick = 1'b0;
  logic [5:0] procFlags = '0;
  logic [2:0] pwrFlags = '0;
  logic       userLed = 1'b0;
  logic       procLed;
  logic       pwrLed;

  int    vectors = 0;
  int    misses = 0;
  string req = "R1";

  // reference model state
  int mSlot = 0;
  int mProcLen = -1;
  int mPwrLen = -1;
  int procLens [6] = '{8, 5, 4, 3, 2, 1};
  int pwrLens  [3] = '{8, 2, 1};

  always #5 clk = ~clk;

  blink_code_led dut_i (
    .clk(clk), .rstN(rstN), .slotTick(slotTick),
    .condFlags(procFlags), .userLed(userLed), .ledOut(procLed)
  );

  blink_code_led #(
    .NUM_COND(3), .SLOT_COUNT(8), .CODE_LENS(12'h128),
    .IDLE_FOLLOW(1'b0), .IDLE_LEVEL(1'b1)
  ) dut_pwr_i (
    .clk(clk), .rstN(rstN), .slotTick(slotTick),
    .condFlags(pwrFlags), .userLed(userLed), .ledOut(pwrLed)
  );

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mSlot = 0; mProcLen = -1; mPwrLen = -1;
    end else if (slotTick) begin
      if (mSlot == 7) begin
        mSlot = 0;
        mProcLen = -1;
        for (int i = 0; i < 6; i++)
          if (procFlags[i] && mProcLen < 0) mProcLen = procLens[i];
        mPwrLen = -1;
        for (int i = 0; i < 3; i++)
          if (pwrFlags[i] && mPwrLen < 0) mPwrLen = pwrLens[i];
      end else begin
        mSlot = mSlot + 1;
      end
    end
  end

  task automatic checkOut();
    logic expP, expW;
    expP = (mProcLen < 0) ? userLed : (mSlot < mProcLen);
    expW = (mPwrLen < 0) ? 1'b1 : (mSlot < mPwrLen);
    vectors++;
    if (procLed !== expP) begin
      misses++;
      $display("FAIL %s processor instance: ledOut=%b expected %b", req, procLed, expP);
    end
    vectors++;
    if (pwrLed !== expW) begin
      misses++;
      $display("FAIL %s power instance: ledOut=%b expected %b", req, pwrLed, expW);
    end
  endtask

  task automatic drive(input bit tk, input logic [5:0] pf, input logic [2:0] wf, input bit ul);
    @(negedge clk);
    checkOut();
    slotTick = tk; procFlags = pf; pwrFlags = wf; userLed = ul;
  endtask

  initial begin
    // R1: reset holds idle; userLed toggles through reset
    req = "R1";
    for (int c = 0; c < 4; c++) drive(1'b1, 6'h3f, 3'h7, c[0]);
    @(negedge clk); checkOut(); rstN = 1'b1;
    slotTick = 1'b0; procFlags = '0; pwrFlags = '0;
    for (int c = 0; c < 4; c++) drive(1'b0, '0, '0, c[0]);

    // R3, R8: each single flag over three full frames
    req = "R3/R8";
    for (int k = 0; k < 6; k++)
      for (int c = 0; c < 24; c++)
        drive(1'b1, 6'(1 << k), 3'(1 << (k % 3)), 1'b0);

    // R2: sparse ticks keep the slot still between strobes
    req = "R2";
    for (int c = 0; c < 72; c++) drive((c % 3) == 0, 6'h08, 3'h2, 1'b1);

    // R4: several flags at once
    req = "R4";
    for (int c = 0; c < 240; c++) drive(1'b1, 6'($urandom), 3'($urandom), 1'b0);

    // R9: short flag pulses away from the boundary, starting from idle
    req = "R9";
    for (int c = 0; c < 16; c++) drive(1'b1, '0, '0, 1'b0);
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 8; c++)
        drive(1'b1, (c == 2 || c == 3) ? 6'h21 : 6'h00,
              (c == 3 || c == 4) ? 3'h5 : 3'h0, 1'b1);

    // R5: flags and ticks change freely; codes switch only at boundaries
    req = "R5";
    for (int c = 0; c < 600; c++)
      drive(1'($urandom), (($urandom % 4) == 0) ? 6'h00 : 6'($urandom),
            3'($urandom), 1'($urandom));

    // R6, R7: idle following and steady idle level
    req = "R6/R7";
    for (int c = 0; c < 24; c++) drive(1'b1, '0, '0, 1'b0);
    for (int c = 0; c < 48; c++) drive(1'($urandom), '0, '0, 1'($urandom));

    @(negedge clk); checkOut();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule